// File: doc/BRIEF.md
# Memory-Mapped Peripheral Address Decoder

This block sits between a processor's data port and the things that port can reach: a data RAM and two device registers. On every access it looks at the full address and the store strobe. It raises exactly one write enable for the target, or none, and it picks which source answers a load. The two device registers and the read-data multiplexer live inside the block. The RAM lives outside it: the RAM takes its write enable from the block and returns its read data to the block.

The highest part of the address space, from `IO_BASE` up to the top, is reserved for devices. Device one answers at `DEV1_ADDR` and device two at `DEV2_ADDR`. Any other address inside that range is a hole. A store to a hole is dropped, and a load from a hole returns zero. Every address below the range belongs to the RAM.

Top module: `mmio_decoder`

## Requirements
- R1: A store (`mem_write`=1) to address 0xFFFFFFF4 asserts `we_dev1` and leaves `we_mem` and `we_dev2` low.
- R2: A store to address 0xFFFFFFF8 asserts `we_dev2` and leaves `we_mem` and `we_dev1` low.
- R3: A store to any address below 0xFFFFFF00 asserts only `we_mem`. When `mem_write`=0, all three write enables are low whatever the address.
- R4: `rd_sel` is 2'b01 for 0xFFFFFFF4 and 2'b10 for 0xFFFFFFF8. It is 2'b11 for every other address at or above 0xFFFFFF00, and 2'b00 for every address below 0xFFFFFF00.
- R5: A device register takes `wdata` on the rising clock edge at which its write enable is high. At every other edge it holds its value.
- R6: A load from 0xFFFFFFF4 or 0xFFFFFFF8 returns the current contents of device register 1 or device register 2 on `rdata`, in the same cycle.
- R7: A store to any other address at or above 0xFFFFFF00 changes neither device register and raises no write enable. A load from such an address returns zero.
- R8: Reset is synchronous and active high. At the edge where `rst`=1, both device registers become zero, and reset takes priority over a store in the same cycle.
- R9: For an address below 0xFFFFFF00, `rdata` equals `mem_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; device registers load on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the device registers |
| mem_write | input | 1 | Store strobe from the processor |
| addr | input | ADDR_W | Byte address from the processor |
| wdata | input | DATA_W | Store data from the processor |
| mem_rdata | input | DATA_W | Read data returned by the external RAM |
| we_mem | output | 1 | Write enable to the external RAM |
| we_dev1 | output | 1 | Write enable of device register 1 |
| we_dev2 | output | 1 | Write enable of device register 2 |
| rd_sel | output | 2 | Read-source code: 00 RAM, 01 device 1, 10 device 2, 11 zero |
| dev1_q | output | DATA_W | Contents of device register 1 |
| dev2_q | output | DATA_W | Contents of device register 2 |
| rdata | output | DATA_W | Load data returned to the processor |

## Verification
The bench builds the block with its default parameters: 32-bit data and addresses, the device range starting at 0xFFFFFF00, and the devices at 0xFFFFFFF4 and 0xFFFFFFF8. With these values it can reach the edge of the range directly: 0xFFFFFEFC as the last RAM word, and 0xFFFFFF00 and 0xFFFFFFFC as holes on either side of the two devices. A 64-word RAM model indexed by the low address bits lets the bench check that loads from the RAM and loads from the devices do not interfere with each other.

// File: rtl/mmio_decoder.sv
module mmio_decoder #(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] IO_BASE   = 32'hFFFF_FF00,
  parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
  parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              we_mem,
  output logic              we_dev1,
  output logic              we_dev2,
  output logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] dev1_q,
  output logic [DATA_W-1:0] dev2_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [1:0] SEL_MEM  = 2'b00;
  localparam logic [1:0] SEL_DEV1 = 2'b01;
  localparam logic [1:0] SEL_DEV2 = 2'b10;
  localparam logic [1:0] SEL_NONE = 2'b11;

  logic in_io, hit1, hit2;

  assign in_io = (addr >= IO_BASE);
  assign hit1  = (addr == DEV1_ADDR);
  assign hit2  = (addr == DEV2_ADDR);

  assign we_mem  = mem_write & ~in_io;
  assign we_dev1 = mem_write & hit1;
  assign we_dev2 = mem_write & hit2;

  always_comb begin
    if (hit1)       rd_sel = SEL_DEV1;
    else if (hit2)  rd_sel = SEL_DEV2;
    else if (in_io) rd_sel = SEL_NONE;
    else            rd_sel = SEL_MEM;
  end

  always_ff @(posedge clk) begin
    if (rst)          dev1_q <= '0;
    else if (we_dev1) dev1_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          dev2_q <= '0;
    else if (we_dev2) dev2_q <= wdata;
  end

  always_comb begin
    case (rd_sel)
      SEL_MEM:  rdata = mem_rdata;
      SEL_DEV1: rdata = dev1_q;
      SEL_DEV2: rdata = dev2_q;
      default:  rdata = '0;
    endcase
  end

  p_we_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({we_mem, we_dev1, we_dev2}))
    else $error("write enables overlap");

  p_no_we_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_write |-> !(we_mem || we_dev1 || we_dev2))
    else $error("write enable without store");

  p_dev1_load_r5: assert property (@(posedge clk) disable iff (rst)
    we_dev1 |=> dev1_q == $past(wdata))
    else $error("device 1 missed a store");

  p_dev1_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we_dev1 |=> $stable(dev1_q))
    else $error("device 1 changed without enable");

  p_dev2_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we_dev2 |=> $stable(dev2_q))
    else $error("device 2 changed without enable");

  p_dev1_read_r6: assert property (@(posedge clk) disable iff (rst)
    rd_sel == SEL_DEV1 |-> rdata == dev1_q)
    else $error("device 1 read mismatch");

  p_hole_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd_sel == SEL_NONE |-> (rdata == '0 && !we_mem))
    else $error("hole access leaked");

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (dev1_q == '0 && dev2_q == '0))
    else $error("reset did not clear devices");

  p_mem_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_sel == SEL_MEM |-> rdata == mem_rdata)
    else $error("memory read mismatch");

endmodule

// File: tb/mmio_decoder_bench.sv
module mmio_decoder_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        mem_write;
  logic [31:0] addr, wdata, mem_rdata;
  logic        we_mem, we_dev1, we_dev2;
  logic [1:0]  rd_sel;
  logic [31:0] dev1_q, dev2_q, rdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mmio_decoder u_mmio_decoder (
    .clk(clk), .rst(rst), .mem_write(mem_write), .addr(addr), .wdata(wdata),
    .mem_rdata(mem_rdata), .we_mem(we_mem), .we_dev1(we_dev1), .we_dev2(we_dev2),
    .rd_sel(rd_sel), .dev1_q(dev1_q), .dev2_q(dev2_q), .rdata(rdata)
  );

  logic [31:0] ram [0:63];
  initial for (int i = 0; i < 64; i++) ram[i] = 32'h0;
  always @(posedge clk) if (we_mem) ram[addr[7:2]] <= wdata;
  assign mem_rdata = ram[addr[7:2]];

  // {store, addr, wdata, {we_mem,we_dev1,we_dev2}, rd_sel}
  localparam int NV = 9;
  localparam logic [69:0] VEC [0:NV-1] = '{
    {1'b1, 32'h0000_0004, 32'h1111_1111, 3'b100, 2'b00},
    {1'b1, 32'hFFFF_FFF4, 32'h0000_002A, 3'b010, 2'b01},
    {1'b1, 32'hFFFF_FFF8, 32'h0000_55AA, 3'b001, 2'b10},
    {1'b1, 32'hFFFF_FF00, 32'hDEAD_0000, 3'b000, 2'b11},
    {1'b1, 32'hFFFF_FFFC, 32'h0000_BEEF, 3'b000, 2'b11},
    {1'b0, 32'hFFFF_FFF4, 32'h7777_7777, 3'b000, 2'b01},
    {1'b1, 32'hFFFF_FEFC, 32'h0000_1234, 3'b100, 2'b00},
    {1'b0, 32'h0000_0004, 32'h9999_9999, 3'b000, 2'b00},
    {1'b1, 32'hFFFF_FFF5, 32'hABCD_0000, 3'b000, 2'b11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    mem_write = w; addr = a; wdata = d;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] e1, e2;
    rst = 1'b1; mem_write = 1'b0; addr = 32'h0; wdata = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 reset dev1", dev1_q, 32'h0);
    check("R8 reset dev2", dev2_q, 32'h0);
    rst = 1'b0;
    e1 = 32'h0; e2 = 32'h0;

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      drive(v[69], v[68:37], v[36:5]);
      check("R1 R2 R3 write enables", {29'h0, we_mem, we_dev1, we_dev2}, {29'h0, v[4:2]});
      check("R4 read select", {30'h0, rd_sel}, {30'h0, v[1:0]});
      if (v[69] && v[68:37] == 32'hFFFF_FFF4) e1 = v[36:5];
      if (v[69] && v[68:37] == 32'hFFFF_FFF8) e2 = v[36:5];
      @(negedge clk); #1;
      check("R5 R7 dev1 contents", dev1_q, e1);
      check("R5 R7 dev2 contents", dev2_q, e2);
    end

    drive(1'b0, 32'hFFFF_FFF4, 32'h0);
    check("R6 load dev1", rdata, 32'h0000_002A);
    drive(1'b0, 32'hFFFF_FFF8, 32'h0);
    check("R6 load dev2", rdata, 32'h0000_55AA);
    drive(1'b0, 32'hFFFF_FF00, 32'h0);
    check("R7 load hole base", rdata, 32'h0);
    drive(1'b0, 32'hFFFF_FFFC, 32'h0);
    check("R7 load hole top", rdata, 32'h0);
    drive(1'b0, 32'h0000_0004, 32'h0);
    check("R9 load ram word 1", rdata, 32'h1111_1111);
    drive(1'b0, 32'hFFFF_FEFC, 32'h0);
    check("R9 load last ram word", rdata, 32'h0000_1234);
    drive(1'b0, 32'hFFFF_FF3C, 32'h0);
    check("R7 hole aliasing ram index", rdata, 32'h0);

    drive(1'b1, 32'hFFFF_FFF4, 32'h5A5A_5A5A);
    @(negedge clk); #1;
    check("R5 dev1 reload", dev1_q, 32'h5A5A_5A5A);
    check("R6 load after reload", rdata, 32'h5A5A_5A5A);

    mem_write = 1'b1; addr = 32'hFFFF_FFF4; wdata = 32'hFFFF_0001; rst = 1'b1;
    @(negedge clk); #1;
    check("R8 reset beats store dev1", dev1_q, 32'h0);
    check("R8 reset clears dev2", dev2_q, 32'h0);
    rst = 1'b0; mem_write = 1'b0;
    @(negedge clk); #1;
    check("R8 dev1 stays zero", dev1_q, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule